// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the mode controller that sits beside a small processor core and decides which clocks, regulators and flash supply stay alive when the core asks to sleep. A wait-for-interrupt strobe parks only the CPU clock and leaves the oscillator, the main regulator and the flash running. A halt strobe leads either to active halt or to full halt. Active halt is chosen when the auto-wakeup timer or the independent watchdog is enabled, and it keeps the slow wakeup clock running. Full halt stops every clock and hands the core supply to the low-power regulator.

On the way out of a halt state the block restarts the chip in a fixed order. The main regulator ramps first, then the crystal oscillator stabilises, then the flash wakes. A step is skipped when the state being left did not switch that resource off. The CPU clock is released only when the last step has finished. A fast-wake option forces the core to resume on the internal RC oscillator instead of the crystal. An activation-level option lets an interrupt routine that was entered from wait drop straight back into wait.

The regulators and the flash array are represented only by their fixed wake delays, which are parameters counted in clock cycles.

Top module: `lpm_seq`

## Requirements
- R1: After reset the core runs: cpu_clk_stop=0, mreg_en=1, lpreg_en=0, flash_pd=0, hsi_en=1, xtal_en=0, awu_clk_en=0, irq_unmask=0.
- R2: A wfi_req pulse stops only the CPU clock. The oscillator, the main regulator and the flash stay on, and irq_unmask=1. An irq_any sampled in wait restarts the CPU clock exactly WAIT_LAT cycles after the sampling edge.
- R3: halt_req enters active halt (awu_clk_en=1, both oscillators off, CPU stopped) when awu_en or iwdg_en is 1. With both at 0 it enters full halt.
- R4: In full halt all clocks are off, mreg_en=0 and lpreg_en=1. Only ext_wake leaves it; irq_any and awu_evt have no effect.
- R5: In active halt, cfg_ah_lpreg=0 keeps the main regulator (mreg_en=1, lpreg_en=0). cfg_ah_lpreg=1 selects the low-power regulator with mreg_en=0.
- R6: Active halt entered with awu_en=0 (watchdog only) ignores ext_wake and awu_evt. Only reset leaves it.
- R7: flash_pd in active halt equals cfg_ah_flash_pd. In full halt flash_pd=1 unless cfg_halt_flash_on=1.
- R8: With cfg_fast_wake=1 a halt wakeup resumes on the internal RC (hsi_en=1, xtal_en=0). Otherwise it resumes on the clock selected before entry. clk_sw_valid with clk_sw_xtal=1 in run selects the crystal.
- R9: Waking onto the crystal inserts XTAL_LONG stabilisation cycles, or XTAL_SHORT cycles when xtal_short=1.
- R10: A halt wakeup runs REG_DLY cycles when the main regulator was off, then the crystal step, then FLASH_DLY cycles when the flash was powered down. Steps that are not needed are skipped, and the CPU clock restarts right after the last step.
- R11: When al_bit=1 and the core last woke from wait, an isr_done pulse in run returns to wait. With al_bit=0 the pulse is ignored.
- R12: mreg_en and lpreg_en are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfi_req | input | 1 | Wait-for-interrupt strobe from the core |
| halt_req | input | 1 | Halt strobe from the core |
| irq_any | input | 1 | Any pending interrupt (wait wakeup) |
| ext_wake | input | 1 | External, GPIO or halt-capable peripheral wake |
| awu_evt | input | 1 | Auto-wakeup timer expiry |
| awu_en | input | 1 | Auto-wakeup timer enabled |
| iwdg_en | input | 1 | Independent watchdog enabled |
| cfg_ah_lpreg | input | 1 | Use low-power regulator in active halt |
| cfg_ah_flash_pd | input | 1 | Power down flash in active halt |
| cfg_halt_flash_on | input | 1 | Keep flash on in full halt |
| cfg_fast_wake | input | 1 | Resume on internal RC after halt |
| xtal_short | input | 1 | Use the short crystal stabilisation count |
| al_bit | input | 1 | Activation level: return to wait after service |
| isr_done | input | 1 | Return-from-interrupt strobe |
| clk_sw_valid | input | 1 | Clock source change request (run only) |
| clk_sw_xtal | input | 1 | Requested source: 1 crystal, 0 internal RC |
| cpu_clk_stop | output | 1 | CPU clock gated |
| hsi_en | output | 1 | Internal RC oscillator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| awu_clk_en | output | 1 | Slow wakeup clock enable |
| mreg_en | output | 1 | Main regulator enable |
| lpreg_en | output | 1 | Low-power regulator enable |
| flash_pd | output | 1 | Flash power-down |
| irq_unmask | output | 1 | Interrupts forced enabled while in wait |

## Verification
The assertions assume that the configuration inputs, awu_en and iwdg_en do not change while the sequencer sits in a low-power or wake state, because the regulator and flash outputs there follow them directly. The stimulus changes configuration only while the core runs, and only between scenarios. Every strobe is one cycle wide. The watchdog-only scenario is left through reset alone, since no other input can end it.

// File: rtl/lpm_seq.sv
module lpm_seq #(
  parameter int REG_DLY    = 8,
  parameter int XTAL_LONG  = 2048,
  parameter int XTAL_SHORT = 256,
  parameter int FLASH_DLY  = 4,
  parameter int WAIT_LAT   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wfi_req,
  input  logic halt_req,
  input  logic irq_any,
  input  logic ext_wake,
  input  logic awu_evt,
  input  logic awu_en,
  input  logic iwdg_en,
  input  logic cfg_ah_lpreg,
  input  logic cfg_ah_flash_pd,
  input  logic cfg_halt_flash_on,
  input  logic cfg_fast_wake,
  input  logic xtal_short,
  input  logic al_bit,
  input  logic isr_done,
  input  logic clk_sw_valid,
  input  logic clk_sw_xtal,
  output logic cpu_clk_stop,
  output logic hsi_en,
  output logic xtal_en,
  output logic awu_clk_en,
  output logic mreg_en,
  output logic lpreg_en,
  output logic flash_pd,
  output logic irq_unmask
);

  localparam int M1   = (REG_DLY > FLASH_DLY) ? REG_DLY : FLASH_DLY;
  localparam int M2   = (XTAL_LONG > XTAL_SHORT) ? XTAL_LONG : XTAL_SHORT;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXD = (M3 > WAIT_LAT) ? M3 : WAIT_LAT;
  localparam int CW   = $clog2(MAXD) + 1;

  typedef enum logic [2:0] {
    S_RUN, S_WAIT, S_WWAKE, S_AHALT, S_HALT, S_WREG, S_WOSC, S_WFL
  } st_t;

  st_t           st, nxt;
  logic [CW-1:0] cnt, nxt_cnt, osc_dly;
  logic          src_xtal, al_ret, nd_osc, nd_fl;
  logic          wake_lp, need_reg, new_x, need_fl, in_run_dom, osc_on;

  assign osc_dly  = xtal_short ? CW'(XTAL_SHORT - 1) : CW'(XTAL_LONG - 1);
  assign wake_lp  = ((st == S_AHALT) && awu_en && (awu_evt || ext_wake)) ||
                    ((st == S_HALT) && ext_wake);
  assign need_reg = (st == S_HALT) || cfg_ah_lpreg;
  assign new_x    = src_xtal && !cfg_fast_wake;
  assign need_fl  = (st == S_HALT) ? !cfg_halt_flash_on : cfg_ah_flash_pd;

  always_comb begin
    nxt     = st;
    nxt_cnt = (cnt == '0) ? '0 : cnt - 1'b1;
    unique case (st)
      S_RUN: begin
        if (halt_req)
          nxt = (awu_en || iwdg_en) ? S_AHALT : S_HALT;
        else if (wfi_req || (isr_done && al_bit && al_ret))
          nxt = S_WAIT;
      end
      S_WAIT: if (irq_any) begin nxt = S_WWAKE; nxt_cnt = CW'(WAIT_LAT - 1); end
      S_WWAKE: if (cnt == '0) nxt = S_RUN;
      S_AHALT, S_HALT: begin
        if (wake_lp) begin
          if (need_reg)     begin nxt = S_WREG; nxt_cnt = CW'(REG_DLY - 1); end
          else if (new_x)   begin nxt = S_WOSC; nxt_cnt = osc_dly; end
          else if (need_fl) begin nxt = S_WFL;  nxt_cnt = CW'(FLASH_DLY - 1); end
          else                    nxt = S_RUN;
        end
      end
      S_WREG: begin
        if (cnt == '0) begin
          if (nd_osc)     begin nxt = S_WOSC; nxt_cnt = osc_dly; end
          else if (nd_fl) begin nxt = S_WFL;  nxt_cnt = CW'(FLASH_DLY - 1); end
          else                  nxt = S_RUN;
        end
      end
      S_WOSC: begin
        if (cnt == '0) begin
          if (nd_fl) begin nxt = S_WFL; nxt_cnt = CW'(FLASH_DLY - 1); end
          else             nxt = S_RUN;
        end
      end
      S_WFL: if (cnt == '0) nxt = S_RUN;
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RUN;
      cnt      <= '0;
      src_xtal <= 1'b0;
      al_ret   <= 1'b0;
      nd_osc   <= 1'b0;
      nd_fl    <= 1'b0;
    end else begin
      st  <= nxt;
      cnt <= nxt_cnt;
      if (st == S_RUN && clk_sw_valid) src_xtal <= clk_sw_xtal;
      if (st == S_RUN && halt_req)     al_ret   <= 1'b0;
      if (st == S_WAIT && irq_any)     al_ret   <= 1'b1;
      if (wake_lp) begin
        src_xtal <= new_x;
        nd_osc   <= new_x;
        nd_fl    <= need_fl;
      end
    end
  end

  assign in_run_dom   = (st == S_RUN) || (st == S_WAIT) || (st == S_WWAKE);
  assign osc_on       = in_run_dom || (st == S_WOSC) || (st == S_WFL);
  assign cpu_clk_stop = (st != S_RUN);
  assign hsi_en       = osc_on && !src_xtal;
  assign xtal_en      = osc_on && src_xtal;
  assign awu_clk_en   = (st == S_AHALT);
  assign lpreg_en     = (st == S_HALT) || ((st == S_AHALT) && cfg_ah_lpreg);
  assign mreg_en      = !lpreg_en;
  assign flash_pd     = (st == S_HALT)  ? !cfg_halt_flash_on :
                        (st == S_AHALT) ? cfg_ah_flash_pd :
                        ((st == S_WREG) || (st == S_WOSC)) ? nd_fl : 1'b0;
  assign irq_unmask   = (st == S_WAIT) || (st == S_WWAKE);

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic awu_en,
  input logic cpu_clk_stop,
  input logic hsi_en,
  input logic xtal_en,
  input logic awu_clk_en,
  input logic mreg_en,
  input logic lpreg_en,
  input logic flash_pd,
  input logic irq_unmask
);

  // R12
  no_dual_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mreg_en && lpreg_en));

  // R4
  halt_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lpreg_en && !awu_clk_en) |-> (cpu_clk_stop && !hsi_en && !xtal_en));

  // R2
  wait_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_unmask |-> (cpu_clk_stop && mreg_en && !flash_pd && (hsi_en || xtal_en)));

  // R10
  run_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_stop |-> (mreg_en && !flash_pd && $onehot0({hsi_en, xtal_en}) && (hsi_en || xtal_en)));

  // R3
  ahalt_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awu_clk_en |-> (cpu_clk_stop && !hsi_en && !xtal_en));

  // R6
  wdog_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(awu_clk_en) && !$past(awu_en) && !awu_en) |-> awu_clk_en);

endmodule

bind lpm_seq lpm_seq_chk u_chk (.*);

// File: tb/tb_lpm_seq.sv
`timescale 1ns/1ps
module tb_lpm_seq;
  localparam int REG_DLY = 8, XTAL_LONG = 2048, XTAL_SHORT = 256, FLASH_DLY = 4, WAIT_LAT = 10;

  logic clk = 0, rst_n = 0;
  logic wfi_req = 0, halt_req = 0, irq_any = 0, ext_wake = 0, awu_evt = 0;
  logic awu_en = 0, iwdg_en = 0, cfg_ah_lpreg = 0, cfg_ah_flash_pd = 0;
  logic cfg_halt_flash_on = 0, cfg_fast_wake = 0, xtal_short = 0, al_bit = 0;
  logic isr_done = 0, clk_sw_valid = 0, clk_sw_xtal = 0;
  logic cpu_clk_stop, hsi_en, xtal_en, awu_clk_en, mreg_en, lpreg_en, flash_pd, irq_unmask;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  lpm_seq #(.REG_DLY(REG_DLY), .XTAL_LONG(XTAL_LONG), .XTAL_SHORT(XTAL_SHORT),
            .FLASH_DLY(FLASH_DLY), .WAIT_LAT(WAIT_LAT)) dut (.*);

  // reference model: 0 run,1 wait,2 wait-wake,3 active halt,4 halt,5 wake step
  int m = 0, cur = 0, left = 0;
  int qk[$], qd[$];
  bit x = 0, alr = 0, mfl = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = 0; x = 0; alr = 0; mfl = 0; qk.delete(); qd.delete();
    end else begin
      case (m)
        0: begin
          if (clk_sw_valid) x = clk_sw_xtal;
          if (halt_req) begin m = (awu_en || iwdg_en) ? 3 : 4; alr = 0; end
          else if (wfi_req || (isr_done && al_bit && alr)) m = 1;
        end
        1: if (irq_any) begin m = 2; left = WAIT_LAT; alr = 1; end
        2: if (left == 1) m = 0; else left--;
        3, 4: begin
          bit wk, full;
          full = (m == 4);
          wk = full ? ext_wake : (awu_en && (awu_evt || ext_wake));
          if (wk) begin
            x = x && !cfg_fast_wake;
            mfl = full ? !cfg_halt_flash_on : cfg_ah_flash_pd;
            if (full || cfg_ah_lpreg) begin qk.push_back(1); qd.push_back(REG_DLY); end
            if (x) begin qk.push_back(2); qd.push_back(xtal_short ? XTAL_SHORT : XTAL_LONG); end
            if (mfl) begin qk.push_back(3); qd.push_back(FLASH_DLY); end
            if (qk.size() == 0) m = 0;
            else begin m = 5; cur = qk.pop_front(); left = qd.pop_front(); end
          end
        end
        5: begin
          if (left == 1) begin
            if (qk.size() == 0) m = 0;
            else begin cur = qk.pop_front(); left = qd.pop_front(); end
          end else left--;
        end
        default: m = 0;
      endcase
    end
  end

  function automatic logic [7:0] expected();
    bit stop, osc, lp, fpd;
    stop = (m != 0);
    osc  = (m <= 2) || (m == 5 && cur != 1);
    lp   = (m == 4) || (m == 3 && cfg_ah_lpreg);
    fpd  = (m == 4) ? !cfg_halt_flash_on : (m == 3) ? cfg_ah_flash_pd :
           (m == 5 && cur != 3) ? mfl : 1'b0;
    return {stop, osc && !x, osc && x, m == 3, !lp, lp, fpd, (m == 1 || m == 2)};
  endfunction

  always @(negedge clk) begin
    logic [7:0] act, exp;
    cycles++;
    act = {cpu_clk_stop, hsi_en, xtal_en, awu_clk_en, mreg_en, lpreg_en, flash_pd, irq_unmask};
    exp = expected();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d outputs actual %b expected %b", tag, cycles, act, exp);
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic strobe(ref logic s);
    s = 1; tick(1); s = 0;
  endtask

  // wake inputs are already driven; returns cycles stopped after the sampling edge
  task automatic time_wake(output int n);
    tick(1);
    irq_any = 0; ext_wake = 0; awu_evt = 0;
    n = 1;
    while (cpu_clk_stop) begin tick(1); n++; end
    n = n - 1;
  endtask

  initial begin
    int n;
    tick(2); rst_n = 1; tick(1);
    tag = "R1";
    check("R1", {cpu_clk_stop, mreg_en, lpreg_en, flash_pd, hsi_en, xtal_en}, 6'b010010, "reset outputs");

    tag = "R2";
    strobe(wfi_req); tick(3);
    check("R2", {cpu_clk_stop, hsi_en, mreg_en, flash_pd, irq_unmask}, 5'b11101, "wait outputs");
    irq_any = 1; time_wake(n);
    check("R2", n, WAIT_LAT, "wait wake latency");

    tag = "R11";
    al_bit = 1; strobe(wfi_req); tick(2); irq_any = 1; time_wake(n);
    strobe(isr_done); tick(1);
    check("R11", {cpu_clk_stop, irq_unmask}, 2'b11, "return to wait after service");
    irq_any = 1; time_wake(n);
    al_bit = 0; strobe(isr_done); tick(2);
    check("R11", cpu_clk_stop, 0, "service end ignored with al_bit clear");

    tag = "R4";
    strobe(halt_req); tick(2);
    check("R3", awu_clk_en, 0, "full halt chosen without timers");
    strobe(irq_any); strobe(awu_evt); tick(3);
    check("R4", {cpu_clk_stop, mreg_en, lpreg_en, hsi_en, xtal_en}, 5'b10100, "halt ignores irq and timer");
    check("R7", flash_pd, 1, "flash down in halt by default");
    tag = "R10";
    ext_wake = 1; time_wake(n);
    check("R10", n, REG_DLY + FLASH_DLY, "halt wake regulator+flash");

    tag = "R9";
    clk_sw_valid = 1; clk_sw_xtal = 1; tick(1); clk_sw_valid = 0;
    awu_en = 1; cfg_ah_lpreg = 1; cfg_ah_flash_pd = 1;
    strobe(halt_req); tick(2);
    check("R5", {awu_clk_en, mreg_en, lpreg_en}, 3'b101, "active halt on low-power regulator");
    check("R7", flash_pd, 1, "flash down in active halt when selected");
    awu_evt = 1; time_wake(n);
    check("R9", n, REG_DLY + XTAL_LONG + FLASH_DLY, "long crystal wake");
    check("R8", {xtal_en, hsi_en}, 2'b10, "resume on previous crystal");

    cfg_ah_lpreg = 0; cfg_ah_flash_pd = 0; xtal_short = 1;
    strobe(halt_req); tick(2);
    check("R5", {mreg_en, lpreg_en, flash_pd}, 3'b100, "active halt on main regulator, flash on");
    awu_evt = 1; time_wake(n);
    check("R9", n, XTAL_SHORT, "short crystal wake");

    tag = "R8";
    cfg_fast_wake = 1; awu_en = 0;
    strobe(halt_req); tick(2);
    ext_wake = 1; time_wake(n);
    check("R8", {xtal_en, hsi_en}, 2'b01, "fast wake on internal RC");
    check("R10", n, REG_DLY + FLASH_DLY, "fast wake skips crystal");
    cfg_fast_wake = 0;

    tag = "R7";
    cfg_halt_flash_on = 1; strobe(halt_req); tick(2);
    check("R7", flash_pd, 0, "flash kept on in halt");
    ext_wake = 1; time_wake(n);
    check("R10", n, REG_DLY, "regulator only wake");
    cfg_halt_flash_on = 0;

    tag = "R6";
    iwdg_en = 1; strobe(halt_req); tick(2);
    check("R3", awu_clk_en, 1, "watchdog alone selects active halt");
    strobe(ext_wake); strobe(awu_evt); tick(20);
    check("R6", {cpu_clk_stop, awu_clk_en}, 2'b11, "watchdog-only halt ignores wakes");
    rst_n = 0; tick(1); rst_n = 1; iwdg_en = 0; tick(2);
    check("R6", cpu_clk_stop, 0, "reset leaves watchdog-only halt");
    tag = "R12";
    check("R12", mreg_en & lpreg_en, 0, "regulators exclusive");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule